// File: doc/BRIEF.md
# SPI Slave-Select Controller

This block produces the slave-select lines of an SPI master. A select configuration word chooses which of up to eight lines take part, whether software drives them directly or the transfer engine drives them automatically, and the electrical polarity seen at the pads. In automatic mode the chosen lines assert when the shifter reports activity. They release once the shifter is idle and the transmit queue is empty. With the hold option set, they stay asserted across such gaps until an end-of-message pulse arrives.

All changes at the pads are deferred to cycles where the serial clock sits at its idle level, so a target never sees a partial clock edge while selected. The pad output enables follow the block enable and an output-disable input, which lets the lines be tristated when the controller is off.

Top module: `spi_sel_ctrl`

## Requirements
- R1: After reset the select pads read all ones (deasserted, active-low), the pad enables read all zeros, and the configuration word is all zeros.
- R2: A write loads the configuration word: bits [7:0] are the line mask, bit 8 selects direct mode, bit 9 selects the pad polarity.
- R3: In direct mode the logical select of each line equals its mask bit, whatever the activity inputs do.
- R4: With the polarity bit at 0 the pad is the inverse of the logical select; with it at 1 the pad equals the logical select.
- R5: In automatic mode the masked lines assert two clock edges after busy is seen high, and release two edges after busy is low while the transmit queue is empty (hold option off).
- R6: In automatic mode without hold, the lines stay asserted while busy is low but the transmit queue still has data.
- R7: With the hold option set, asserted lines stay asserted through busy-low, queue-empty gaps and release two edges after the end-of-message pulse.
- R8: The pad values never change on an edge where the serial-clock-idle input is low; a pending change appears on the first edge where it is high.
- R9: Every pad enable is 1 one edge after enable is high with output-disable low, and 0 one edge after either condition fails.
- R10: While the block is disabled the automatic select state is cleared and stays clear, even with busy high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable |
| oe_off | input | 1 | Forces the pad enables off |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 10 | Configuration word: mask, direct bit, polarity bit |
| hold_en | input | 1 | Keep select asserted until end of message |
| xfer_busy | input | 1 | Shifter is moving a frame |
| txq_empty | input | 1 | Transmit queue is empty |
| msg_done | input | 1 | One-cycle end-of-message pulse |
| sclk_idle | input | 1 | Serial clock is at its idle level |
| ss_o | output | 8 | Select pad values |
| ss_oe | output | 8 | Select pad output enables |

## Verification
Automatic select is driven with a busy burst, a gap with queue data still pending, and a gap with the queue empty; these separate the release condition from the bare busy signal. The same gap is repeated with hold set, and an end-of-message pulse then distinguishes the held state from a stuck one. Direct mode is tried with busy high to show activity is ignored, both polarities are tried with the same mask to separate inversion from masking, and a busy rise while the serial clock is not idle shows that the pad update is deferred and not lost.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  localparam int SSC_MAXW = 32;

  typedef enum logic {
    SEL_IDLE = 1'b0,
    SEL_HELD = 1'b1
  } auto_st_e;

  // Logical select vector: 1 means the line is selected.
  function automatic logic [SSC_MAXW-1:0] sel_target(
    input logic [SSC_MAXW-1:0] mask,
    input logic                direct,
    input logic                held
  );
    if (direct) return mask;
    return held ? mask : '0;
  endfunction

  // Pad value from logical select and polarity.
  function automatic logic [SSC_MAXW-1:0] pad_level(
    input logic [SSC_MAXW-1:0] sel,
    input logic                act_high
  );
    return act_high ? sel : ~sel;
  endfunction
endpackage

// File: rtl/ssc_sel_reg.sv
module ssc_sel_reg #(
  parameter int NUM_SEL = 8,
  localparam int CFG_W  = NUM_SEL + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [CFG_W-1:0]   cfg_wdata,
  output logic [NUM_SEL-1:0] mask,
  output logic               direct,
  output logic               act_high
);
  logic [CFG_W-1:0] cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_wdata;
  end

  assign mask     = cfg_q[NUM_SEL-1:0];
  assign direct   = cfg_q[NUM_SEL];
  assign act_high = cfg_q[NUM_SEL+1];

  assert_cfg_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (mask == $past(cfg_wdata[NUM_SEL-1:0])) && (direct == $past(cfg_wdata[NUM_SEL])));
endmodule

// File: rtl/ssc_auto_ctl.sv
module ssc_auto_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic hold_en,
  input  logic xfer_busy,
  input  logic txq_empty,
  input  logic msg_done,
  output logic held
);
  import ssc_pkg::*;

  auto_st_e st_q, st_d;
  logic     start_ev, gap_release_ev, end_release_ev;

  assign start_ev       = xfer_busy;
  assign gap_release_ev = !hold_en && !xfer_busy && txq_empty;
  assign end_release_ev = hold_en && msg_done;

  always_comb begin
    st_d = st_q;
    if (!enable) begin
      st_d = SEL_IDLE;
    end else begin
      case (st_q)
        SEL_IDLE: if (start_ev) st_d = SEL_HELD;
        SEL_HELD: if (gap_release_ev || end_release_ev) st_d = SEL_IDLE;
        default:  st_d = SEL_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SEL_IDLE;
    else        st_q <= st_d;
  end

  assign held = (st_q == SEL_HELD);

  assert_auto_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !held && xfer_busy) |=> held);
  assert_gap_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && held && !hold_en && !txq_empty) |=> held);
  assert_hold_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && held && hold_en && !msg_done) |=> held);
  assert_disable_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !held);
endmodule

// File: rtl/ssc_pad_stage.sv
module ssc_pad_stage #(
  parameter int NUM_SEL = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk_idle,
  input  logic               enable,
  input  logic               oe_off,
  input  logic [NUM_SEL-1:0] pad_next,
  output logic [NUM_SEL-1:0] ss_o,
  output logic [NUM_SEL-1:0] ss_oe
);
  logic drive_ok;
  assign drive_ok = enable && !oe_off;

  for (genvar i = 0; i < NUM_SEL; i++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ss_o[i]  <= 1'b1;
        ss_oe[i] <= 1'b0;
      end else begin
        if (sclk_idle) ss_o[i] <= pad_next[i];
        ss_oe[i] <= drive_ok;
      end
    end
  end

  assert_pad_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_idle |=> $stable(ss_o));
  assert_oe_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !oe_off) |=> (ss_oe == {NUM_SEL{1'b1}}));
  assert_oe_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(enable && !oe_off) |=> (ss_oe == '0));
  assert_oe_uniform_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_oe == '0) || (ss_oe == {NUM_SEL{1'b1}}));
endmodule

// File: rtl/spi_sel_ctrl.sv
module spi_sel_ctrl #(
  parameter int NUM_SEL = 8,
  localparam int CFG_W  = NUM_SEL + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               oe_off,
  input  logic               cfg_we,
  input  logic [CFG_W-1:0]   cfg_wdata,
  input  logic               hold_en,
  input  logic               xfer_busy,
  input  logic               txq_empty,
  input  logic               msg_done,
  input  logic               sclk_idle,
  output logic [NUM_SEL-1:0] ss_o,
  output logic [NUM_SEL-1:0] ss_oe
);
  import ssc_pkg::*;

  logic [NUM_SEL-1:0]  mask;
  logic                direct, act_high, held;
  logic [SSC_MAXW-1:0] mask_w, sel_w, pad_w;
  logic [NUM_SEL-1:0]  pad_next;

  ssc_sel_reg #(.NUM_SEL(NUM_SEL)) u_reg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .mask(mask), .direct(direct), .act_high(act_high)
  );

  ssc_auto_ctl u_auto (
    .clk(clk), .rst_n(rst_n), .enable(enable), .hold_en(hold_en),
    .xfer_busy(xfer_busy), .txq_empty(txq_empty), .msg_done(msg_done),
    .held(held)
  );

  assign mask_w   = SSC_MAXW'(mask);
  assign sel_w    = sel_target(mask_w, direct, held);
  assign pad_w    = pad_level(sel_w, act_high);
  assign pad_next = pad_w[NUM_SEL-1:0];

  ssc_pad_stage #(.NUM_SEL(NUM_SEL)) u_pad (
    .clk(clk), .rst_n(rst_n), .sclk_idle(sclk_idle), .enable(enable),
    .oe_off(oe_off), .pad_next(pad_next), .ss_o(ss_o), .ss_oe(ss_oe)
  );

  initial assert_width_ok: assert (NUM_SEL >= 1 && NUM_SEL <= SSC_MAXW);

  assert_direct_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (direct && sclk_idle) |=> (ss_o == ($past(act_high) ? $past(mask) : ~$past(mask))));
  assert_unmasked_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_idle && !act_high) |=> ((ss_o | $past(mask)) == {NUM_SEL{1'b1}}));
endmodule

// File: tb/sim_spi_sel_ctrl.sv
module sim_spi_sel_ctrl;
  typedef struct {
    string      tag;
    logic [7:0] pad;
    logic [7:0] oe;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, oe_off = 1'b0, cfg_we = 1'b0;
  logic [9:0] cfg_wdata = '0;
  logic hold_en = 1'b0, xfer_busy = 1'b0, txq_empty = 1'b1;
  logic msg_done = 1'b0, sclk_idle = 1'b1;
  logic [7:0] ss_o, ss_oe;

  int total = 0, bad = 0;
  bit done = 1'b0;
  exp_t sb[$];

  always #2 clk = ~clk;

  spi_sel_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .oe_off(oe_off),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .hold_en(hold_en),
    .xfer_busy(xfer_busy), .txq_empty(txq_empty), .msg_done(msg_done),
    .sclk_idle(sclk_idle), .ss_o(ss_o), .ss_oe(ss_oe)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_io(input string tag, input logic [7:0] p, input logic [7:0] o);
    exp_t e;
    e.tag = tag; e.pad = p; e.oe = o;
    sb.push_back(e);
  endtask

  task automatic write_cfg(input logic [9:0] w);
    cfg_we = 1'b1; cfg_wdata = w;
    cyc(1);
    cfg_we = 1'b0;
  endtask

  // Monitor: compares queued expectations just after the falling edge.
  always begin
    @(negedge clk);
    #1;
    while (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      total++;
      if (ss_o !== e.pad || ss_oe !== e.oe) begin
        bad++;
        $display("FAIL %s: pad=%02h oe=%02h expected pad=%02h oe=%02h",
                 e.tag, ss_o, ss_oe, e.pad, e.oe);
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not complete");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cyc(3);
    expect_io("R1 pads in reset", 8'hFF, 8'h00);
    rst_n = 1'b1;
    cyc(2);
    expect_io("R1 state after reset", 8'hFF, 8'h00);

    enable = 1'b1;
    cyc(1);
    expect_io("R9 enable drives pads", 8'hFF, 8'hFF);
    oe_off = 1'b1;
    cyc(1);
    expect_io("R9 output-disable tristates", 8'hFF, 8'h00);
    oe_off = 1'b0;
    cyc(1);
    expect_io("R9 output-disable released", 8'hFF, 8'hFF);

    // R2: mask 0x05, automatic, active-low
    write_cfg(10'h005);
    cyc(2);
    expect_io("R2 mask alone selects nothing when idle", 8'hFF, 8'hFF);
    xfer_busy = 1'b1; txq_empty = 1'b0;
    cyc(2);
    expect_io("R5 busy asserts masked lines", 8'hFA, 8'hFF);
    xfer_busy = 1'b0;
    cyc(3);
    expect_io("R6 gap with queued data keeps select", 8'hFA, 8'hFF);
    txq_empty = 1'b1;
    cyc(2);
    expect_io("R5 idle and empty releases select", 8'hFF, 8'hFF);

    // R4: same mask, active-high pads
    write_cfg(10'h205);
    cyc(2);
    expect_io("R4 active-high idle level", 8'h00, 8'hFF);
    xfer_busy = 1'b1;
    cyc(2);
    expect_io("R4 active-high asserted level", 8'h05, 8'hFF);
    xfer_busy = 1'b0;
    cyc(2);
    expect_io("R5 release with active-high pads", 8'h00, 8'hFF);

    // R7: hold option
    hold_en = 1'b1;
    xfer_busy = 1'b1;
    cyc(2);
    expect_io("R7 held select asserts", 8'h05, 8'hFF);
    xfer_busy = 1'b0; txq_empty = 1'b1;
    cyc(4);
    expect_io("R7 select kept through empty gap", 8'h05, 8'hFF);
    msg_done = 1'b1;
    cyc(1);
    msg_done = 1'b0;
    cyc(1);
    expect_io("R7 end of message releases", 8'h00, 8'hFF);
    hold_en = 1'b0;

    // R8: pad update deferred while serial clock not idle
    sclk_idle = 1'b0;
    xfer_busy = 1'b1;
    cyc(3);
    expect_io("R8 pads frozen while clock active", 8'h00, 8'hFF);
    sclk_idle = 1'b1;
    cyc(1);
    expect_io("R8 pending change applied at idle", 8'h05, 8'hFF);
    xfer_busy = 1'b0;
    cyc(2);
    expect_io("R5 release after deferred assert", 8'h00, 8'hFF);

    // R3: direct mode ignores activity
    write_cfg(10'h33C);
    cyc(2);
    expect_io("R3 direct mode active-high", 8'h3C, 8'hFF);
    write_cfg(10'h13C);
    cyc(2);
    expect_io("R3 direct mode active-low", 8'hC3, 8'hFF);
    xfer_busy = 1'b1; txq_empty = 1'b0;
    cyc(3);
    expect_io("R3 busy has no effect in direct mode", 8'hC3, 8'hFF);
    xfer_busy = 1'b0; txq_empty = 1'b1;

    // R10: disable clears automatic state
    write_cfg(10'h205);
    xfer_busy = 1'b1;
    cyc(2);
    expect_io("R10 asserted before disable", 8'h05, 8'hFF);
    enable = 1'b0;
    cyc(1);
    expect_io("R9 disable tristates pads", 8'h05, 8'h00);
    cyc(1);
    expect_io("R10 disable releases select", 8'h00, 8'h00);
    cyc(3);
    expect_io("R10 busy ignored while disabled", 8'h00, 8'h00);
    xfer_busy = 1'b0;

    cyc(2);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule